// File: doc/BRIEF.md
# Configuration phase tracker

This block follows a programmable target device through its configuration life cycle and reports the current phase in a read-only status word. It watches a supply-good flag, a request to hold the target's configuration input low, the target's completion and health lines, and a pulse that marks the end of the clocks issued after loading. From these it moves a three-bit phase code through powering up, reset, configuration, init and user operation. A fault code covers a target that loses its completion or health line after loading has finished.

The block also registers the five-bit mode-strap code that was sampled from the board and decides whether the code names a supported loading mode. Software reads the phase, the strap code and the supported flag from a single status word at offset 0 over a simple 32-bit read port. Pin sampling, synchronisation and the data path that loads the target are handled elsewhere.

Top module: `cfg_phase_tracker`

## Requirements
- R1: After synchronous reset, the phase is 0 (powering up), and `rd_data` is 0 until a status read returns data.
- R2: When `pwr_good` is low at a clock edge, the phase is 0 after that edge, whatever phase it was in.
- R3: The block leaves phase 0 on the first edge that finds `pwr_good` high after it has already been high on STABLE_CYCLES consecutive earlier edges. The new phase is 1 (reset) if `hold_req` is high, and 2 (configuration) otherwise. A drop of `pwr_good` clears this count.
- R4: In any phase other than 0, `hold_req` high moves the phase to 1. In phase 1, `hold_req` low moves the phase to 2.
- R5: In phase 2, `tgt_health` low returns the phase to 1. This also covers the failure case where completion and health are both low. `tgt_done` and `tgt_health` both high move the phase to 3 (init). Otherwise the phase stays at 2.
- R6: In phase 3, with both lines still high, a `burst_done` pulse moves the phase to 4 (user). Without the pulse the phase stays at 3.
- R7: In phase 3 or 4, `tgt_done` low or `tgt_health` low moves the phase to 5 (unknown). Phase 5 is left only through `hold_req` (R4) or a supply drop (R2).
- R8: The read port is registered. A read with `rd_en` high at offset 0 returns the status word on the next cycle, with bits [2:0] holding the phase, [7:3] the strap code registered at the previous edge, [8] the supported flag and [31:9] zero. A read at any other offset, and any cycle with `rd_en` low, returns 0.
- R9: A strap code is supported when it is below 16 and its two low bits are not both 1. This makes 0-2, 4-6, 8-10 and 12-14 supported. All other codes of the 32 are flagged as not supported (bit 8 clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Target supply good flag |
| hold_req | input | 1 | Request to hold the target's configuration input low |
| strap_in | input | 5 | Sampled mode-strap code |
| tgt_done | input | 1 | Target reports loading complete |
| tgt_health | input | 1 | Target health line, high when no error |
| burst_done | input | 1 | One-cycle pulse, end of the clocks issued after loading |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Registered read data |

## Verification
The bound checker checks the local phase rules on every cycle: forced power-up on supply loss, the hold request that always lands in reset, fall-back to reset on a health fault during loading, the init-to-user step, the fault state that holds, and zero read data when no read is made. It also checks that unsupported strap codes are never flagged as supported. The power qualification window, the full sequence of phases and the decode of all 32 strap codes are shown only by the bench scenarios. The bench compares these against its behavioural model on every clock.

// File: rtl/cfg_phase_pkg.sv
`timescale 1ns/1ps
package cfg_phase_pkg;

    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_PWRUP   = 3'd0,
        PH_RESET   = 3'd1,
        PH_CONFIG  = 3'd2,
        PH_INIT    = 3'd3,
        PH_USER    = 3'd4,
        PH_UNKNOWN = 3'd5
    } phase_e;

    // target-side inputs grouped for the sequencer
    typedef struct packed {
        logic hold;
        logic done;
        logic health;
        logic burst;
    } tgt_pins_t;

    // supported loading modes: below 16 and low two bits not both set
    function automatic logic strap_supported(input logic [4:0] code);
        return (code[4] == 1'b0) && (code[1:0] != 2'b11);
    endfunction

    function automatic logic link_lost(input tgt_pins_t p);
        return !(p.done && p.health);
    endfunction

endpackage

// File: rtl/cfg_pwr_qual.sv
`timescale 1ns/1ps
module cfg_pwr_qual #(
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    output logic pwr_stable
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_CYCLES);

    logic [CNT_W-1:0] hi_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != CNT_MAX) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    assign pwr_stable = (hi_cnt_q == CNT_MAX);
endmodule

// File: rtl/cfg_strap_dec.sv
`timescale 1ns/1ps
module cfg_strap_dec #(
    parameter int STRAP_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [STRAP_W-1:0] strap_q,
    output logic               strap_ok
);
    import cfg_phase_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) strap_q <= '0;
        else     strap_q <= strap_in;
    end

    generate
        if (STRAP_W == 5) begin : g_native
            assign strap_ok = strap_supported(strap_q);
        end else begin : g_wide
            logic upper_clear;
            assign upper_clear = (strap_q >> 4) == '0;
            assign strap_ok = upper_clear && (strap_q[1:0] != 2'b11);
        end
    endgenerate
endmodule

// File: rtl/cfg_phase_fsm.sv
`timescale 1ns/1ps
module cfg_phase_fsm (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pwr_good,
    input  logic                      pwr_stable,
    input  cfg_phase_pkg::tgt_pins_t  pins,
    output cfg_phase_pkg::phase_e     phase_q
);
    import cfg_phase_pkg::*;

    phase_e phase_d;

    always_comb begin
        phase_d = phase_q;
        if (!pwr_good) begin
            phase_d = PH_PWRUP;
        end else if (phase_q == PH_PWRUP) begin
            if (pwr_stable) phase_d = pins.hold ? PH_RESET : PH_CONFIG;
        end else if (pins.hold) begin
            phase_d = PH_RESET;
        end else begin
            case (phase_q)
                PH_RESET:  phase_d = PH_CONFIG;
                PH_CONFIG: begin
                    if (!pins.health)                phase_d = PH_RESET;
                    else if (pins.done)              phase_d = PH_INIT;
                end
                PH_INIT: begin
                    if (link_lost(pins))             phase_d = PH_UNKNOWN;
                    else if (pins.burst)             phase_d = PH_USER;
                end
                PH_USER: begin
                    if (link_lost(pins))             phase_d = PH_UNKNOWN;
                end
                PH_UNKNOWN: phase_d = PH_UNKNOWN;
                default:    phase_d = PH_UNKNOWN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_PWRUP;
        else     phase_q <= phase_d;
    end
endmodule

// File: rtl/cfg_status_port.sv
`timescale 1ns/1ps
module cfg_status_port #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int STRAP_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  cfg_phase_pkg::phase_e phase,
    input  logic [STRAP_W-1:0]    strap,
    input  logic                  strap_ok,
    output logic [DATA_W-1:0]     rd_data
);
    import cfg_phase_pkg::*;

    localparam int STRAP_LSB = PHASE_W;
    localparam int OK_BIT    = STRAP_LSB + STRAP_W;
    localparam logic [ADDR_W-1:0] STATUS_OFS = '0;

    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word = '0;
        status_word[PHASE_W-1:0]          = phase;
        status_word[STRAP_LSB +: STRAP_W] = strap;
        status_word[OK_BIT]               = strap_ok;
    end

    always_ff @(posedge clk) begin
        if (rst)                                  rd_data <= '0;
        else if (rd_en && rd_addr == STATUS_OFS)  rd_data <= status_word;
        else                                      rd_data <= '0;
    end
endmodule

// File: rtl/cfg_phase_tracker.sv
`timescale 1ns/1ps
module cfg_phase_tracker #(
    parameter int STABLE_CYCLES = 16,
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 8,
    parameter int STRAP_W       = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_good,
    input  logic               hold_req,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic               tgt_done,
    input  logic               tgt_health,
    input  logic               burst_done,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data
);
    import cfg_phase_pkg::*;

    logic         pwr_stable;
    logic [STRAP_W-1:0] strap_q;
    logic         strap_ok;
    tgt_pins_t    pins;
    phase_e       phase_q;

    assign pins = '{hold: hold_req, done: tgt_done, health: tgt_health, burst: burst_done};

    cfg_pwr_qual #(.STABLE_CYCLES(STABLE_CYCLES)) u_pwr (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .pwr_stable(pwr_stable)
    );

    cfg_strap_dec #(.STRAP_W(STRAP_W)) u_strap (
        .clk(clk), .rst(rst), .strap_in(strap_in), .strap_q(strap_q), .strap_ok(strap_ok)
    );

    cfg_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .pwr_stable(pwr_stable),
        .pins(pins), .phase_q(phase_q)
    );

    cfg_status_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) u_port (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .phase(phase_q), .strap(strap_q), .strap_ok(strap_ok), .rd_data(rd_data)
    );
endmodule

// File: rtl/cfg_phase_tracker_chk.sv
`timescale 1ns/1ps
module cfg_phase_tracker_chk #(
    parameter int DATA_W  = 32,
    parameter int STRAP_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               pwr_good,
    input logic               hold_req,
    input logic               tgt_done,
    input logic               tgt_health,
    input logic               burst_done,
    input logic               rd_en,
    input logic [2:0]         mode,
    input logic [STRAP_W-1:0] strap,
    input logic               strap_ok,
    input logic [DATA_W-1:0]  rd_data
);
    // R2
    pwr_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> mode == 3'd0);

    // R3
    pwrup_exit_chk: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd0 |=> mode <= 3'd2);

    // R4
    hold_to_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_good && hold_req && mode != 3'd0) |=> mode == 3'd1);

    // R5
    cfg_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_good && !hold_req && mode == 3'd2 && !tgt_health) |=> mode == 3'd1);

    // R6
    init_to_user_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_good && !hold_req && mode == 3'd3 && tgt_done && tgt_health && burst_done)
        |=> mode == 3'd4);

    // R7
    unknown_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_good && !hold_req && mode == 3'd5) |=> mode == 3'd5);

    // R8
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);

    // R9
    strap_reject_chk: assert property (@(posedge clk) disable iff (rst)
        ((strap >> 4) != '0 || strap[1:0] == 2'b11) |-> !strap_ok);
endmodule

bind cfg_phase_tracker cfg_phase_tracker_chk #(.DATA_W(DATA_W), .STRAP_W(STRAP_W)) u_chk (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .hold_req(hold_req),
    .tgt_done(tgt_done), .tgt_health(tgt_health), .burst_done(burst_done),
    .rd_en(rd_en), .mode(phase_q), .strap(strap_q), .strap_ok(strap_ok),
    .rd_data(rd_data)
);

// File: tb/sim_cfg_phase_tracker.sv
`timescale 1ns/1ps
module sim_cfg_phase_tracker;
    localparam int STB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_good = 1'b0;
    logic        hold_req = 1'b0;
    logic [4:0]  strap_in = 5'd0;
    logic        tgt_done = 1'b0;
    logic        tgt_health = 1'b0;
    logic        burst_done = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = 8'd0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    cfg_phase_tracker #(.STABLE_CYCLES(STB)) u0 (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .hold_req(hold_req),
        .strap_in(strap_in), .tgt_done(tgt_done), .tgt_health(tgt_health),
        .burst_done(burst_done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic sup(input int code);
        return (code < 16) && ((code % 4) != 3);
    endfunction

    // behavioural reference model
    int          m_mode = 0;
    int          m_cnt = 0;
    int          m_strap = 0;
    logic [31:0] m_rd = 32'd0;
    bit          model_live = 0;

    always @(posedge clk) begin
        int nm;
        logic [31:0] nr;
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_strap = 0; m_rd = 32'd0;
        end else begin
            nr = 32'd0;
            if (rd_en && rd_addr == 8'd0)
                nr = (32'(sup(m_strap)) << 8) | (32'(m_strap) << 3) | 32'(m_mode);
            nm = m_mode;
            if (!pwr_good) begin
                nm = 0; m_cnt = 0;
            end else begin
                if (m_mode == 0) begin
                    if (m_cnt >= STB) nm = hold_req ? 1 : 2;
                end else if (hold_req) nm = 1;
                else if (m_mode == 1) nm = 2;
                else if (m_mode == 2) begin
                    if (!tgt_health) nm = 1;
                    else if (tgt_done) nm = 3;
                end else if (m_mode == 3) begin
                    if (!tgt_done || !tgt_health) nm = 5;
                    else if (burst_done) nm = 4;
                end else if (m_mode == 4) begin
                    if (!tgt_done || !tgt_health) nm = 5;
                end
                if (m_cnt < STB) m_cnt = m_cnt + 1;
            end
            m_mode = nm;
            m_strap = int'(strap_in);
            m_rd = nr;
        end
        model_live = 1;
    end

    always @(negedge clk) begin
        if (model_live) chk({cur_req, " model"}, rd_data, m_rd);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        v = rd_data;
        rd_en = 1'b0; rd_addr = 8'd0;
    endtask

    task automatic chk_mode(input string tag, input int exp);
        logic [31:0] v;
        rd(8'd0, v);
        chk(tag, {29'd0, v[2:0]}, 32'(exp));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 rd_data after reset", rd_data, 32'd0);
        chk_mode("R1 reset phase", 0);

        cur_req = "R3";
        pwr_good = 1'b1; hold_req = 1'b1; tgt_health = 1'b1;
        step(2);
        chk_mode("R3 not yet stable", 0);
        step(4);
        chk_mode("R3 exit to reset with hold", 1);

        cur_req = "R4";
        hold_req = 1'b0;
        step(2);
        chk_mode("R4 release to config", 2);

        cur_req = "R5";
        step(2);
        chk_mode("R5 config holds without done", 2);
        tgt_done = 1'b1;
        step(2);
        chk_mode("R5 done and health to init", 3);

        cur_req = "R6";
        step(3);
        chk_mode("R6 init holds without pulse", 3);
        burst_done = 1'b1; step(1); burst_done = 1'b0; step(1);
        chk_mode("R6 pulse to user", 4);

        cur_req = "R7";
        tgt_health = 1'b0;
        step(2);
        chk_mode("R7 health loss to unknown", 5);
        tgt_health = 1'b1;
        step(3);
        chk_mode("R7 unknown holds", 5);
        cur_req = "R4";
        hold_req = 1'b1;
        step(2);
        chk_mode("R4 hold from unknown", 1);
        tgt_done = 1'b0; hold_req = 1'b0;
        step(2);
        chk_mode("R4 release to config", 2);

        cur_req = "R5";
        tgt_health = 1'b0;
        @(negedge clk);
        rd(8'd0, v);
        chk("R5 both low back to reset", {29'd0, v[2:0]}, 32'd1);
        tgt_health = 1'b1;
        step(2);
        chk_mode("R5 recovers to config", 2);

        cur_req = "R2";
        pwr_good = 1'b0;
        step(1);
        chk_mode("R2 supply loss from config", 0);
        cur_req = "R3";
        pwr_good = 1'b1; step(2); pwr_good = 1'b0; step(1); pwr_good = 1'b1;
        step(3);
        chk_mode("R3 glitch restarts count", 0);
        step(2);
        chk_mode("R3 exit to config without hold", 2);

        cur_req = "R2";
        tgt_done = 1'b1; step(2);
        burst_done = 1'b1; step(1); burst_done = 1'b0; step(1);
        chk_mode("R2 reached user", 4);
        pwr_good = 1'b0;
        step(1);
        chk_mode("R2 supply loss from user", 0);
        pwr_good = 1'b1; tgt_done = 1'b0;
        step(8);

        cur_req = "R8";
        strap_in = 5'h0D;
        step(2);
        rd(8'd0, v);
        chk("R8 status word", v, 32'h0000_016A);
        rd(8'd4, v);
        chk("R8 other offset", v, 32'd0);
        rd(8'h80, v);
        chk("R8 high offset", v, 32'd0);

        cur_req = "R9";
        for (int k = 0; k < 32; k++) begin
            strap_in = 5'(k);
            step(1);
            rd(8'd0, v);
            chk("R9 supported flag", {31'd0, v[8]}, {31'd0, sup(k)});
            chk("R9 strap field", {27'd0, v[7:3]}, 32'(k));
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule